// File: doc/BRIEF.md
# Dual-Set Zero-Sequence Offset Injector

This block serves a converter that drives two three-phase outputs from one shared leg set. The top switches follow one set of phase references and the bottom switches follow a second set. To keep the first set's modulation signals above the second set's, each set needs its own common-mode offset. Each offset is built from the largest and smallest phase of both sets and from the DC-link value. Two zero-vector share factors, alpha and beta, weight these terms. The block adds each offset to the three phases of its own set and saturates the results.

A sample is offered with a one-cycle strobe. The offsets and the six corrected references appear two cycles later with a valid strobe and are held until the next result. Software writes alpha and beta as unsigned fixed-point factors. A pair whose sum exceeds one is refused, and the last accepted pair stays in use. A discontinuous mode ignores the written factors. It derives alpha from the sign of a supplied cosine of three times the first output's angle plus a modulation angle, and sets beta to one minus alpha.

Top module: `znx_offset_injector`

## Requirements
- R1: `out_vld` is high for exactly one cycle, two clock edges after each edge at which `in_vld` was sampled high, and is low otherwise.
- R2: With phases, `vdc` and factors taken as integers and ONE = 32768, `off1` = floor((vdc*(16384-a) + (a-32768)*max1 + a*max2 - a*(min1+min2)) / 32768). Here max1 and min1 are the extremes of `ref1_*`, max2 and min2 are the extremes of `ref2_*`, and a is the alpha in effect.
- R3: `off2` = floor((vdc*(b-16384) + (b-32768)*min2 + b*min1 - b*(max1+max2)) / 32768), with b the beta in effect.
- R4: `fac_alpha` and `fac_beta` are unsigned with 32768 meaning one. On a strobe outside discontinuous mode, a pair whose sum is at most 32768 is used and stored. A pair with a larger sum is ignored, and the stored pair is used instead. After reset the stored pair is alpha = 0, beta = 0.
- R5: In discontinuous mode, alpha is 32768 if `cos3` > 0, 16384 if `cos3` = 0 and 0 if `cos3` < 0, and beta = 32768 - alpha. In this mode `fac_alpha` and `fac_beta` are ignored and the stored pair is unchanged.
- R6: Each offset is saturated to the signed range of the phase width, -32768 to 32767 at the default width.
- R7: `mod1_x` = saturate(`ref1_x` + `off1`) and `mod2_x` = saturate(`ref2_x` + `off2`), using the already saturated offsets.
- R8: After reset, `out_vld` is low and all offsets and corrected references read zero.
- R9: Offsets and corrected references keep their values in every cycle that `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample strobe |
| dis_mode | input | 1 | Discontinuous factor mode |
| cos3 | input | 16 | Signed cosine value whose sign picks alpha in discontinuous mode |
| vdc | input | 16 | Unsigned DC-link value |
| fac_alpha | input | 16 | Alpha, unsigned, 32768 = one |
| fac_beta | input | 16 | Beta, unsigned, 32768 = one |
| ref1_a | input | 16 | First set, phase a, signed |
| ref1_b | input | 16 | First set, phase b, signed |
| ref1_c | input | 16 | First set, phase c, signed |
| ref2_a | input | 16 | Second set, phase a, signed |
| ref2_b | input | 16 | Second set, phase b, signed |
| ref2_c | input | 16 | Second set, phase c, signed |
| out_vld | output | 1 | Result strobe |
| off1 | output | 16 | Offset of the first set |
| off2 | output | 16 | Offset of the second set |
| mod1_a | output | 16 | Corrected first set, phase a |
| mod1_b | output | 16 | Corrected first set, phase b |
| mod1_c | output | 16 | Corrected first set, phase c |
| mod2_a | output | 16 | Corrected second set, phase a |
| mod2_b | output | 16 | Corrected second set, phase b |
| mod2_c | output | 16 | Corrected second set, phase c |

## Verification
The only hidden state is the stored factor pair. If it were lost or overwritten by a refused pair or by a discontinuous sample, the change would not show on the strobe that caused it. It would show two cycles after the next strobe that falls back on the pair, as wrong `off1` and `off2` values. The bench therefore follows every refused pair and every discontinuous run with a fallback sample. A pipeline slip shows at once as `out_vld` in the wrong cycle or as outputs that move while the strobe is low.

// File: rtl/znx_pkg.sv
package znx_pkg;

    typedef enum logic [1:0] {
        SRC_HELD = 2'd0,
        SRC_NEW  = 2'd1,
        SRC_DISC = 2'd2
    } fac_src_e;

    // Clamp a value to the signed range of a w-bit word.
    function automatic longint clamp_w(longint v, int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/znx_extrema.sv
module znx_extrema #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] p0,
    input  logic signed [W-1:0] p1,
    input  logic signed [W-1:0] p2,
    output logic signed [W-1:0] hi,
    output logic signed [W-1:0] lo
);
    logic signed [W-1:0] hi01, lo01;

    always_comb begin
        hi01 = (p0 > p1) ? p0 : p1;
        lo01 = (p0 < p1) ? p0 : p1;
        hi   = (hi01 > p2) ? hi01 : p2;
        lo   = (lo01 < p2) ? lo01 : p2;
    end
endmodule

// File: rtl/znx_factor_sel.sv
module znx_factor_sel
    import znx_pkg::*;
#(
    parameter int W  = 16,
    parameter int FB = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 dis,
    input  logic signed [W-1:0]  cos_in,
    input  logic [FB-1:0]        a_in,
    input  logic [FB-1:0]        b_in,
    output logic [FB-1:0]        eff_a,
    output logic [FB-1:0]        eff_b,
    output logic [FB-1:0]        held_a,
    output logic [FB-1:0]        held_b
);
    localparam logic [FB:0]   ONE_X  = (FB+1)'(1) << (FB - 1);
    localparam logic [FB-1:0] ONE_F  = FB'(1) << (FB - 1);
    localparam logic [FB-1:0] HALF_F = FB'(1) << (FB - 2);

    logic [FB:0]   pair_sum;
    logic          pair_ok;
    fac_src_e      src;
    logic [FB-1:0] disc_a;

    always_comb begin
        pair_sum = {1'b0, a_in} + {1'b0, b_in};
        pair_ok  = (pair_sum <= ONE_X);
        if (dis)          src = SRC_DISC;
        else if (pair_ok) src = SRC_NEW;
        else              src = SRC_HELD;

        if (cos_in > 0)       disc_a = ONE_F;
        else if (cos_in == 0) disc_a = HALF_F;
        else                  disc_a = '0;

        unique case (src)
            SRC_DISC: begin eff_a = disc_a; eff_b = ONE_F - disc_a; end
            SRC_NEW:  begin eff_a = a_in;   eff_b = b_in;           end
            default:  begin eff_a = held_a; eff_b = held_b;         end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_a <= '0;
            held_b <= '0;
        end else if (take && src == SRC_NEW) begin
            held_a <= a_in;
            held_b <= b_in;
        end
    end
endmodule

// File: rtl/znx_offset_calc.sv
module znx_offset_calc
    import znx_pkg::*;
#(
    parameter int W     = 16,
    parameter int FB    = 16,
    parameter bit UPPER = 1'b1
) (
    input  logic [W-1:0]        vdc,
    input  logic signed [W-1:0] mx1,
    input  logic signed [W-1:0] mn1,
    input  logic signed [W-1:0] mx2,
    input  logic signed [W-1:0] mn2,
    input  logic [FB-1:0]       fac,
    output logic signed [W-1:0] off
);
    localparam int AW = W + FB + 6;
    localparam logic signed [AW-1:0] ONE_C  = AW'(1) <<< (FB - 1);
    localparam logic signed [AW-1:0] HALF_C = AW'(1) <<< (FB - 2);

    logic signed [AW-1:0] f, vd, p, q, r, dc_term, acc, shv;

    // The own-set extreme, the cross extreme and the opposite pair differ per side.
    generate
        if (UPPER) begin : g_up
            always_comb begin
                p       = AW'(mx1);
                q       = AW'(mx2);
                r       = AW'(mn1) + AW'(mn2);
                dc_term = vd * (HALF_C - f);
            end
        end else begin : g_lo
            always_comb begin
                p       = AW'(mn2);
                q       = AW'(mn1);
                r       = AW'(mx1) + AW'(mx2);
                dc_term = vd * (f - HALF_C);
            end
        end
    endgenerate

    always_comb begin
        f   = AW'($signed({1'b0, fac}));
        vd  = AW'($signed({1'b0, vdc}));
        acc = dc_term + (f - ONE_C) * p + f * q - f * r;
        shv = acc >>> (FB - 1);
        off = W'(clamp_w(longint'(shv), W));
    end
endmodule

// File: rtl/znx_offset_injector.sv
module znx_offset_injector
    import znx_pkg::*;
#(
    parameter int W  = 16,
    parameter int FB = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 dis_mode,
    input  logic signed [W-1:0]  cos3,
    input  logic [W-1:0]         vdc,
    input  logic [FB-1:0]        fac_alpha,
    input  logic [FB-1:0]        fac_beta,
    input  logic signed [W-1:0]  ref1_a,
    input  logic signed [W-1:0]  ref1_b,
    input  logic signed [W-1:0]  ref1_c,
    input  logic signed [W-1:0]  ref2_a,
    input  logic signed [W-1:0]  ref2_b,
    input  logic signed [W-1:0]  ref2_c,
    output logic                 out_vld,
    output logic signed [W-1:0]  off1,
    output logic signed [W-1:0]  off2,
    output logic signed [W-1:0]  mod1_a,
    output logic signed [W-1:0]  mod1_b,
    output logic signed [W-1:0]  mod1_c,
    output logic signed [W-1:0]  mod2_a,
    output logic signed [W-1:0]  mod2_b,
    output logic signed [W-1:0]  mod2_c
);
    localparam int NSET = 2;
    localparam int NPH  = 3 * NSET;

    logic signed [W-1:0] ph_in   [NPH];
    logic signed [W-1:0] ext_hi  [NSET];
    logic signed [W-1:0] ext_lo  [NSET];
    logic [FB-1:0]       eff_a, eff_b, held_a, held_b;

    // stage 1
    logic                s1_vld;
    logic [W-1:0]        s1_vdc;
    logic [FB-1:0]       s1_alpha, s1_beta;
    logic signed [W-1:0] s1_ph [NPH];
    logic signed [W-1:0] s1_hi [NSET];
    logic signed [W-1:0] s1_lo [NSET];

    // stage 2
    logic signed [W-1:0] off_c   [NSET];
    logic signed [W-1:0] mod_c   [NPH];
    logic signed [W-1:0] off_r   [NSET];
    logic signed [W-1:0] mod_r   [NPH];
    logic                vld_r;

    assign ph_in[0] = ref1_a;
    assign ph_in[1] = ref1_b;
    assign ph_in[2] = ref1_c;
    assign ph_in[3] = ref2_a;
    assign ph_in[4] = ref2_b;
    assign ph_in[5] = ref2_c;

    znx_factor_sel #(.W(W), .FB(FB)) u_fac (
        .clk    (clk),
        .rst    (rst),
        .take   (in_vld),
        .dis    (dis_mode),
        .cos_in (cos3),
        .a_in   (fac_alpha),
        .b_in   (fac_beta),
        .eff_a  (eff_a),
        .eff_b  (eff_b),
        .held_a (held_a),
        .held_b (held_b)
    );

    generate
        for (genvar g = 0; g < NSET; g++) begin : g_ext
            znx_extrema #(.W(W)) u_ext (
                .p0 (ph_in[3*g]),
                .p1 (ph_in[3*g+1]),
                .p2 (ph_in[3*g+2]),
                .hi (ext_hi[g]),
                .lo (ext_lo[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_vdc   <= '0;
            s1_alpha <= '0;
            s1_beta  <= '0;
            s1_ph    <= '{default: '0};
            s1_hi    <= '{default: '0};
            s1_lo    <= '{default: '0};
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_vdc   <= vdc;
                s1_alpha <= eff_a;
                s1_beta  <= eff_b;
                s1_ph    <= ph_in;
                s1_hi    <= ext_hi;
                s1_lo    <= ext_lo;
            end
        end
    end

    generate
        for (genvar g = 0; g < NSET; g++) begin : g_off
            znx_offset_calc #(.W(W), .FB(FB), .UPPER(g == 0)) u_calc (
                .vdc (s1_vdc),
                .mx1 (s1_hi[0]),
                .mn1 (s1_lo[0]),
                .mx2 (s1_hi[1]),
                .mn2 (s1_lo[1]),
                .fac ((g == 0) ? s1_alpha : s1_beta),
                .off (off_c[g])
            );
        end
        for (genvar i = 0; i < NPH; i++) begin : g_mod
            always_comb begin
                mod_c[i] = W'(clamp_w(longint'(s1_ph[i]) + longint'(off_c[i/3]), W));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_r <= 1'b0;
            off_r <= '{default: '0};
            mod_r <= '{default: '0};
        end else begin
            vld_r <= s1_vld;
            if (s1_vld) begin
                off_r <= off_c;
                mod_r <= mod_c;
            end
        end
    end

    assign out_vld = vld_r;
    assign off1    = off_r[0];
    assign off2    = off_r[1];
    assign mod1_a  = mod_r[0];
    assign mod1_b  = mod_r[1];
    assign mod1_c  = mod_r[2];
    assign mod2_a  = mod_r[3];
    assign mod2_b  = mod_r[4];
    assign mod2_c  = mod_r[5];
endmodule

// File: rtl/znx_checker.sv
module znx_checker #(
    parameter int W  = 16,
    parameter int FB = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_vld,
    input logic                 dis_mode,
    input logic                 out_vld,
    input logic signed [W-1:0]  off1,
    input logic signed [W-1:0]  off2,
    input logic [FB-1:0]        held_a,
    input logic [FB-1:0]        held_b,
    input logic                 s1_vld,
    input logic [FB-1:0]        s1_alpha,
    input logic [FB-1:0]        s1_beta
);
    localparam logic [FB:0] ONE_X = (FB+1)'(1) << (FB - 1);

    logic [1:0] strobe_sh;
    logic       dis_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_sh <= '0;
            dis_d     <= 1'b0;
        end else begin
            strobe_sh <= {strobe_sh[0], in_vld};
            if (in_vld) dis_d <= dis_mode;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_vld == strobe_sh[1]); // R1

    AST_HELD_PAIR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, held_a} + {1'b0, held_b}) <= ONE_X); // R4

    AST_DISC_SUM_ONE: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && dis_d) |-> (({1'b0, s1_alpha} + {1'b0, s1_beta}) == ONE_X)); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(off1) && $stable(off2))); // R9
endmodule

bind znx_offset_injector znx_checker #(.W(W), .FB(FB)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .dis_mode (dis_mode),
    .out_vld  (out_vld),
    .off1     (off1),
    .off2     (off2),
    .held_a   (held_a),
    .held_b   (held_b),
    .s1_vld   (s1_vld),
    .s1_alpha (s1_alpha),
    .s1_beta  (s1_beta)
);

// File: tb/znx_offset_injector_tb.sv
module znx_offset_injector_tb;
    localparam int W  = 16;
    localparam int FB = 16;

    typedef struct {
        bit     vld;
        longint o1;
        longint o2;
        longint m [6];
        string  tag;
    } ent_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0, dis_mode = 1'b0;
    logic signed [W-1:0] cos3 = '0;
    logic [W-1:0]  vdc = '0;
    logic [FB-1:0] fac_alpha = '0, fac_beta = '0;
    logic signed [W-1:0] ref1_a = '0, ref1_b = '0, ref1_c = '0;
    logic signed [W-1:0] ref2_a = '0, ref2_b = '0, ref2_c = '0;
    logic out_vld;
    logic signed [W-1:0] off1, off2, mod1_a, mod1_b, mod1_c, mod2_a, mod2_b, mod2_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // stimulus for the next tick
    bit     s_vld, s_dis;
    longint s_cos, s_vdc, s_a, s_b;
    longint s_ph [6];
    string  s_tag = "R2";

    // behavioural model state
    longint k_a = 0, k_b = 0;
    ent_t   p1, p2, shown;
    string  idle_tag = "R8";

    always #4 clk = ~clk;

    znx_offset_injector u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .dis_mode(dis_mode), .cos3(cos3),
        .vdc(vdc), .fac_alpha(fac_alpha), .fac_beta(fac_beta),
        .ref1_a(ref1_a), .ref1_b(ref1_b), .ref1_c(ref1_c),
        .ref2_a(ref2_a), .ref2_b(ref2_b), .ref2_c(ref2_c),
        .out_vld(out_vld), .off1(off1), .off2(off2),
        .mod1_a(mod1_a), .mod1_b(mod1_b), .mod1_c(mod1_c),
        .mod2_a(mod2_a), .mod2_b(mod2_b), .mod2_c(mod2_c)
    );

    function automatic longint sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rnd(int lim);
        return longint'(int'($urandom_range(0, 2 * lim))) - lim;
    endfunction

    task automatic cmp(longint act, longint exp, string what, string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        longint mx1, mn1, mx2, mn2, a, b, up, lo;
        ent_t e;
        string tg;
        @(negedge clk);
        // check the state produced by the stimulus two ticks ago
        cmp(longint'(out_vld), longint'(p2.vld), "out_vld", "R1");
        if (p2.vld) shown = p2;
        tg = p2.vld ? p2.tag : idle_tag;
        cmp(longint'(off1), shown.o1, "off1", {"R2/", tg});
        cmp(longint'(off2), shown.o2, "off2", {"R3/", tg});
        cmp(longint'(mod1_a), shown.m[0], "mod1_a", {"R7/", tg});
        cmp(longint'(mod1_b), shown.m[1], "mod1_b", {"R7/", tg});
        cmp(longint'(mod1_c), shown.m[2], "mod1_c", {"R7/", tg});
        cmp(longint'(mod2_a), shown.m[3], "mod2_a", {"R7/", tg});
        cmp(longint'(mod2_b), shown.m[4], "mod2_b", {"R7/", tg});
        cmp(longint'(mod2_c), shown.m[5], "mod2_c", {"R7/", tg});
        idle_tag = "R9";
        // drive
        in_vld    = s_vld;
        dis_mode  = s_dis;
        cos3      = W'(s_cos);
        vdc       = W'(s_vdc);
        fac_alpha = FB'(s_a);
        fac_beta  = FB'(s_b);
        ref1_a = W'(s_ph[0]); ref1_b = W'(s_ph[1]); ref1_c = W'(s_ph[2]);
        ref2_a = W'(s_ph[3]); ref2_b = W'(s_ph[4]); ref2_c = W'(s_ph[5]);
        // model
        e.vld = s_vld;
        e.tag = s_tag;
        e.o1 = 0; e.o2 = 0;
        foreach (e.m[i]) e.m[i] = 0;
        if (s_vld) begin
            if (s_dis) begin
                a = (s_cos > 0) ? 32768 : ((s_cos == 0) ? 16384 : 0);
                b = 32768 - a;
            end else if (s_a + s_b <= 32768) begin
                a = s_a; b = s_b; k_a = s_a; k_b = s_b;
            end else begin
                a = k_a; b = k_b;
            end
            mx1 = s_ph[0]; mn1 = s_ph[0]; mx2 = s_ph[3]; mn2 = s_ph[3];
            for (int i = 1; i < 3; i++) begin
                if (s_ph[i] > mx1) mx1 = s_ph[i];
                if (s_ph[i] < mn1) mn1 = s_ph[i];
                if (s_ph[i+3] > mx2) mx2 = s_ph[i+3];
                if (s_ph[i+3] < mn2) mn2 = s_ph[i+3];
            end
            up = s_vdc * (16384 - a) + (a - 32768) * mx1 + a * mx2 - a * (mn1 + mn2);
            lo = s_vdc * (b - 16384) + (b - 32768) * mn2 + b * mn1 - b * (mx1 + mx2);
            e.o1 = sat16(up >>> 15);
            e.o2 = sat16(lo >>> 15);
            for (int i = 0; i < 6; i++)
                e.m[i] = sat16(s_ph[i] + ((i < 3) ? e.o1 : e.o2));
        end
        p2 = p1;
        p1 = e;
    endtask

    task automatic rand_phases(int lim);
        for (int i = 0; i < 6; i++) s_ph[i] = rnd(lim);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        p1.vld = 0; p2.vld = 0; shown.vld = 0; shown.o1 = 0; shown.o2 = 0;
        foreach (shown.m[i]) begin shown.m[i] = 0; p1.m[i] = 0; p2.m[i] = 0; end
        p1.o1 = 0; p1.o2 = 0; p2.o1 = 0; p2.o2 = 0; p1.tag = "R8"; p2.tag = "R8";
        s_vld = 0; s_dis = 0; s_cos = 0; s_vdc = 20000; s_a = 0; s_b = 0;
        foreach (s_ph[i]) s_ph[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        s_tag = "R8"; tick();

        // R2/R3: one-third share factors, random phases
        s_tag = "R2"; s_vld = 1; s_a = 10923; s_b = 10923;
        for (int k = 0; k < 20; k++) begin rand_phases(12000); tick(); end

        // R4: zero factors accepted, then sum exactly one accepted
        s_tag = "R4"; s_a = 0; s_b = 0;
        for (int k = 0; k < 4; k++) begin rand_phases(12000); tick(); end
        s_a = 20000; s_b = 12768;
        for (int k = 0; k < 3; k++) begin rand_phases(12000); tick(); end
        // R4: sums above one refused, stored pair used
        s_a = 20000; s_b = 12769;
        for (int k = 0; k < 3; k++) begin rand_phases(12000); tick(); end
        s_a = 32768; s_b = 1;
        for (int k = 0; k < 2; k++) begin rand_phases(12000); tick(); end

        // R9: idle gap, outputs hold
        s_vld = 0; s_tag = "R9";
        for (int k = 0; k < 3; k++) begin rand_phases(12000); tick(); end

        // R5: discontinuous mode, all three cosine signs, junk factors
        s_vld = 1; s_dis = 1; s_tag = "R5"; s_a = 1; s_b = 1;
        s_cos = 5;
        for (int k = 0; k < 2; k++) begin rand_phases(12000); tick(); end
        s_cos = 0;
        for (int k = 0; k < 2; k++) begin rand_phases(12000); tick(); end
        s_cos = -7;
        for (int k = 0; k < 2; k++) begin rand_phases(12000); tick(); end
        // R5: stored pair untouched by the mode, refused pair falls back to it
        s_dis = 0; s_a = 40000; s_b = 0;
        for (int k = 0; k < 2; k++) begin rand_phases(12000); tick(); end

        // R6: offsets and corrected values driven into saturation
        s_tag = "R6"; s_vdc = 65535; s_a = 0; s_b = 0;
        s_ph[0] = -30000; s_ph[1] = -30000; s_ph[2] = -30000;
        s_ph[3] = 30000;  s_ph[4] = 30000;  s_ph[5] = 30000;
        tick();
        s_ph[0] = 32000; s_ph[1] = -32000; s_ph[2] = 100;
        s_ph[3] = -32768; s_ph[4] = 32767; s_ph[5] = 0;
        tick();
        for (int k = 0; k < 10; k++) begin
            s_a = longint'(int'($urandom_range(0, 16384)));
            s_b = longint'(int'($urandom_range(0, 16384)));
            rand_phases(32767);
            tick();
        end

        // R7: mixed strobes, factors and values
        s_tag = "R7";
        for (int k = 0; k < 60; k++) begin
            s_vld = ($urandom_range(0, 1) == 1);
            s_dis = ($urandom_range(0, 3) == 0);
            s_cos = rnd(3);
            s_vdc = longint'(int'($urandom_range(0, 65535)));
            s_a = longint'(int'($urandom_range(0, 40000)));
            s_b = longint'(int'($urandom_range(0, 40000)));
            rand_phases(32767);
            tick();
        end

        s_vld = 0; s_dis = 0; s_tag = "R9";
        for (int k = 0; k < 3; k++) tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule